// File: doc/BRIEF.md
# Cache and TLB RAM Debug Reader

This block lets software running at the highest exception level look at the raw contents of the cache tag arrays, the cache data arrays and the TLB array. Software never addresses those arrays directly. It writes a location word to one of five write-only selector registers in the implementation-defined system-register space. The block unpacks the word into way, set or index, and offset fields, and sends one read request to the RAM port. When the RAM answers, the returned word is latched into a bank of four read-only 32-bit result registers, which software then reads one by one.

The register-access channel is valid/ready. The block classifies every request it sees by its encoding. It tells the caller whether it owns the encoding (`acc_claim`) and whether the access is trapped as undefined (`acc_undef`). For a read it also returns the data. An access completes in the cycle where `acc_valid` and `acc_ready` are both high. `acc_ready` drops only for a legal access to one of the nine registers while a RAM lookup is in flight; the caller must then keep the request stable until ready returns. Faulting and unclaimed accesses are never stalled.

On the RAM side the request is valid/ready. `ram_req_valid` and the location fields stay stable until `ram_req_ready` is seen. The response is a single-cycle `ram_rsp_valid` pulse, and exactly one response may arrive for each accepted request.

Top module: `ramdbg_reader`

## Requirements
- R1: Result registers sit at op0=3, op1=3, CRn=15, CRm=0 with op2 0..3 picking result word 0..3. Selectors sit at op0=3, op1=3, CRn=15 with (CRm,op2) = (2,0) data-cache tag, (2,1) instruction-cache tag, (4,0) data-cache data, (4,1) instruction-cache data, (4,2) TLB. On the RAM port these are encoded as `ram_sel` 0, 1, 2, 3, 4 respectively.
- R2: A legal selector write at EL3 launches exactly one RAM request carrying the matching `ram_sel`. The request holds its valid and fields stable until `ram_req_ready` is high.
- R3: The location word is unpacked as follows. Way is bits 31:30. Set for the cache targets is bits 6+SET_W-1:6. Index for the TLB is bits 6+IDX_W-1:6, zero-extended. Offset is bits 5:3 for the two data-read targets and zero for the tag and TLB targets.
- R4: The returned word is placed with bits 31:0 in result word 0, bits 63:32 in word 1, and so on upward.
- R5: `busy` is high from the accepting edge of a selector write until the edge that latches the response. While busy, legal result reads and legal selector writes see `acc_ready` low.
- R6: Any access to the nine registers at EL0, EL1 or EL2 raises `acc_undef` with `acc_ready` high. It starts no RAM request and changes no result register.
- R7: A write to a result register, or a read of a selector register, raises `acc_undef` even at EL3 and has no effect on any state.
- R8: Any other encoding gives `acc_claim` low, `acc_undef` low and `acc_rdata` zero.
- R9: After reset `busy` and `ram_req_valid` are low and all four result words read as zero.
- R10: Result words keep their value until the next response is latched.
- R11: Result-word bits at or above RAM_W read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access request present |
| acc_ready | output | 1 | Access completes this cycle when high with acc_valid |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_write | input | 1 | 1 = register write, 0 = register read |
| acc_el | input | 2 | Exception level of the access |
| acc_wdata | input | 32 | Write data (location word) |
| acc_claim | output | 1 | Encoding belongs to this block |
| acc_undef | output | 1 | Access traps as undefined |
| acc_rdata | output | 32 | Read data for a legal result read, else zero |
| busy | output | 1 | RAM lookup in flight |
| ram_req_valid | output | 1 | RAM read request valid |
| ram_req_ready | input | 1 | RAM accepts the request |
| ram_sel | output | 3 | Target array code (R1) |
| ram_way | output | WAY_W | Way field |
| ram_loc | output | LOC_W | Set or index field |
| ram_ofs | output | OFS_W | Doubleword offset in the line |
| ram_rsp_valid | input | 1 | One-cycle response pulse |
| ram_rsp_data | input | RAM_W | Returned RAM word |

## Verification
The bench builds the block with RAM_W=96, so the fourth result word lies fully above the returned word. This brings the zero-fill of R11 into reach together with the word split of R4. TLB index width is set to 7 against a set width of 8. A TLB request therefore has to show a zero top location bit even when the location word has bit 13 set, which separates index unpacking from set unpacking. Random RAM accept and response delays of zero to three cycles put every stalled access and in-flight fault against both RAM handshake states.

// File: rtl/ramdbg_pkg.sv
package ramdbg_pkg;

  localparam logic [1:0] DBG_OP0 = 2'd3;
  localparam logic [2:0] DBG_OP1 = 3'd3;
  localparam logic [3:0] DBG_CRN = 4'd15;
  localparam logic [3:0] CRM_RESULT = 4'd0;
  localparam logic [3:0] CRM_TAG    = 4'd2;
  localparam logic [3:0] CRM_DATA   = 4'd4;
  localparam int         NUM_WORDS  = 4;
  localparam int         WORD_W     = 32;
  localparam int         BANK_W     = NUM_WORDS * WORD_W;
  localparam logic [1:0] TOP_EL     = 2'd3;

  typedef enum logic [2:0] {
    TGT_DTAG  = 3'd0,
    TGT_ITAG  = 3'd1,
    TGT_DDATA = 3'd2,
    TGT_IDATA = 3'd3,
    TGT_TLB   = 3'd4
  } tgt_e;

  typedef struct packed {
    logic       hit;
    logic       is_result;
    logic [1:0] word;
    tgt_e       tgt;
  } dec_s;

endpackage

// File: rtl/ramdbg_decode.sv
module ramdbg_decode
  import ramdbg_pkg::*;
(
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output dec_s       dec
);

  logic space;
  assign space = (op0 == DBG_OP0) && (op1 == DBG_OP1) && (crn == DBG_CRN);

  always_comb begin
    dec = '{hit: 1'b0, is_result: 1'b0, word: 2'd0, tgt: TGT_DTAG};
    if (space) begin
      unique case (crm)
        CRM_RESULT: begin
          if (op2 < 3'(NUM_WORDS)) begin
            dec.hit       = 1'b1;
            dec.is_result = 1'b1;
            dec.word      = op2[1:0];
          end
        end
        CRM_TAG: begin
          if (op2 == 3'd0) begin
            dec.hit = 1'b1;
            dec.tgt = TGT_DTAG;
          end else if (op2 == 3'd1) begin
            dec.hit = 1'b1;
            dec.tgt = TGT_ITAG;
          end
        end
        CRM_DATA: begin
          if (op2 == 3'd0) begin
            dec.hit = 1'b1;
            dec.tgt = TGT_DDATA;
          end else if (op2 == 3'd1) begin
            dec.hit = 1'b1;
            dec.tgt = TGT_IDATA;
          end else if (op2 == 3'd2) begin
            dec.hit = 1'b1;
            dec.tgt = TGT_TLB;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ramdbg_locfmt.sv
module ramdbg_locfmt
  import ramdbg_pkg::*;
#(
  parameter int WAY_W = 2,
  parameter int SET_W = 8,
  parameter int IDX_W = 7,
  parameter int OFS_W = 3,
  parameter int LOC_W = 8
) (
  input  tgt_e             tgt,
  input  logic [31:0]      word,
  output logic [WAY_W-1:0] way,
  output logic [LOC_W-1:0] loc,
  output logic [OFS_W-1:0] ofs
);

  localparam int LOC_LSB = 6;
  localparam int OFS_LSB = 3;

  logic [LOC_W-1:0] set_f;
  logic [LOC_W-1:0] idx_f;

  assign way = word[31 -: WAY_W];

  generate
    if (SET_W == LOC_W) begin : g_set_full
      assign set_f = word[LOC_LSB +: SET_W];
    end else begin : g_set_ext
      assign set_f = {{(LOC_W-SET_W){1'b0}}, word[LOC_LSB +: SET_W]};
    end
    if (IDX_W == LOC_W) begin : g_idx_full
      assign idx_f = word[LOC_LSB +: IDX_W];
    end else begin : g_idx_ext
      assign idx_f = {{(LOC_W-IDX_W){1'b0}}, word[LOC_LSB +: IDX_W]};
    end
  endgenerate

  always_comb begin
    loc = (tgt == TGT_TLB) ? idx_f : set_f;
    ofs = '0;
    if (tgt == TGT_DDATA || tgt == TGT_IDATA) ofs = word[OFS_LSB +: OFS_W];
  end

endmodule

// File: rtl/ramdbg_seq.sv
module ramdbg_seq
  import ramdbg_pkg::*;
#(
  parameter int RAM_W = 128,
  parameter int WAY_W = 2,
  parameter int LOC_W = 8,
  parameter int OFS_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  tgt_e              tgt,
  input  logic [WAY_W-1:0]  way,
  input  logic [LOC_W-1:0]  loc,
  input  logic [OFS_W-1:0]  ofs,
  output logic              busy,
  output logic              ram_req_valid,
  input  logic              ram_req_ready,
  output logic [2:0]        ram_sel,
  output logic [WAY_W-1:0]  ram_way,
  output logic [LOC_W-1:0]  ram_loc,
  output logic [OFS_W-1:0]  ram_ofs,
  input  logic              ram_rsp_valid,
  input  logic [RAM_W-1:0]  ram_rsp_data,
  output logic [BANK_W-1:0] bank
);

  localparam int PAD_W = BANK_W - RAM_W;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;

  st_e              state;
  logic [RAM_W-1:0] result;
  logic             take;

  assign take          = (state == ST_WAIT) && ram_rsp_valid;
  assign busy          = (state != ST_IDLE);
  assign ram_req_valid = (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      result  <= '0;
      ram_sel <= '0;
      ram_way <= '0;
      ram_loc <= '0;
      ram_ofs <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            ram_sel <= tgt;
            ram_way <= way;
            ram_loc <= loc;
            ram_ofs <= ofs;
            state   <= ST_REQ;
          end
        end
        ST_REQ:  if (ram_req_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (ram_rsp_valid) begin
            result <= ram_rsp_data;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  generate
    if (PAD_W == 0) begin : g_nopad
      assign bank = result;
    end else begin : g_pad
      assign bank = {{PAD_W{1'b0}}, result};
    end
  endgenerate

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req_valid && !ram_req_ready) |=>
      (ram_req_valid && $stable(ram_sel) && $stable(ram_loc) && $stable(ram_way)));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(result));

  assert_busy_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !busy);

endmodule

// File: rtl/ramdbg_reader.sv
module ramdbg_reader
  import ramdbg_pkg::*;
#(
  parameter int RAM_W = 128,
  parameter int WAY_W = 2,
  parameter int SET_W = 8,
  parameter int IDX_W = 7,
  parameter int OFS_W = 3,
  parameter int LOC_W = (SET_W > IDX_W) ? SET_W : IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [1:0]       acc_op0,
  input  logic [2:0]       acc_op1,
  input  logic [3:0]       acc_crn,
  input  logic [3:0]       acc_crm,
  input  logic [2:0]       acc_op2,
  input  logic             acc_write,
  input  logic [1:0]       acc_el,
  input  logic [31:0]      acc_wdata,
  output logic             acc_claim,
  output logic             acc_undef,
  output logic [31:0]      acc_rdata,
  output logic             busy,
  output logic             ram_req_valid,
  input  logic             ram_req_ready,
  output logic [2:0]       ram_sel,
  output logic [WAY_W-1:0] ram_way,
  output logic [LOC_W-1:0] ram_loc,
  output logic [OFS_W-1:0] ram_ofs,
  input  logic             ram_rsp_valid,
  input  logic [RAM_W-1:0] ram_rsp_data
);

  dec_s              dec;
  logic [WAY_W-1:0]  f_way;
  logic [LOC_W-1:0]  f_loc;
  logic [OFS_W-1:0]  f_ofs;
  logic [BANK_W-1:0] bank;
  logic              legal;
  logic              start;

  ramdbg_decode u_dec (
    .op0(acc_op0), .op1(acc_op1), .crn(acc_crn),
    .crm(acc_crm), .op2(acc_op2), .dec(dec)
  );

  ramdbg_locfmt #(
    .WAY_W(WAY_W), .SET_W(SET_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .LOC_W(LOC_W)
  ) u_fmt (
    .tgt(dec.tgt), .word(acc_wdata), .way(f_way), .loc(f_loc), .ofs(f_ofs)
  );

  assign acc_claim = acc_valid && dec.hit;
  assign acc_undef = acc_claim &&
                     ((acc_el != TOP_EL) || (dec.is_result == acc_write));
  assign legal     = acc_claim && !acc_undef;
  assign acc_ready = !(legal && busy);
  assign start     = legal && acc_write && !busy;
  assign acc_rdata = (legal && !acc_write && !busy)
                   ? bank[dec.word*WORD_W +: WORD_W] : '0;

  ramdbg_seq #(
    .RAM_W(RAM_W), .WAY_W(WAY_W), .LOC_W(LOC_W), .OFS_W(OFS_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt(dec.tgt),
    .way(f_way), .loc(f_loc), .ofs(f_ofs), .busy(busy),
    .ram_req_valid(ram_req_valid), .ram_req_ready(ram_req_ready),
    .ram_sel(ram_sel), .ram_way(ram_way), .ram_loc(ram_loc), .ram_ofs(ram_ofs),
    .ram_rsp_valid(ram_rsp_valid), .ram_rsp_data(ram_rsp_data), .bank(bank)
  );

  assert_fault_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_undef) |-> acc_ready);

  assert_fault_no_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && acc_valid && acc_undef) |=> !busy);

  assert_stall_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_claim && !acc_undef) |-> !acc_ready);

  assert_unclaimed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_claim) |-> (!acc_undef && acc_rdata == 32'd0));

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && acc_valid && acc_ready && acc_claim && !acc_undef && acc_write)
      |=> ram_req_valid);

endmodule

// File: tb/ramdbg_reader_test.sv
module ramdbg_reader_test;

  localparam int RAM_W = 96;
  localparam int WAY_W = 2;
  localparam int SET_W = 8;
  localparam int IDX_W = 7;
  localparam int OFS_W = 3;
  localparam int LOC_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0] acc_op0 = '0, acc_el = '0;
  logic [2:0] acc_op1 = '0, acc_op2 = '0;
  logic [3:0] acc_crn = '0, acc_crm = '0;
  logic [31:0] acc_wdata = '0;
  logic acc_ready, acc_claim, acc_undef, busy, ram_req_valid;
  logic [31:0] acc_rdata;
  logic ram_req_ready = 1'b0, ram_rsp_valid = 1'b0;
  logic [2:0] ram_sel;
  logic [WAY_W-1:0] ram_way;
  logic [LOC_W-1:0] ram_loc;
  logic [OFS_W-1:0] ram_ofs;
  logic [RAM_W-1:0] ram_rsp_data = '0;

  int total = 0, bad = 0, req_count = 0;
  logic s_ready, s_claim, s_undef;
  logic [31:0] s_rdata;
  logic [2:0] exp_sel;
  logic [LOC_W-1:0] exp_loc;
  logic [WAY_W-1:0] exp_way;
  logic [OFS_W-1:0] exp_ofs;
  logic [31:0] shadow [4];

  always #2 clk = ~clk;

  ramdbg_reader #(.RAM_W(RAM_W), .WAY_W(WAY_W), .SET_W(SET_W), .IDX_W(IDX_W),
                  .OFS_W(OFS_W)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm),
    .acc_op2(acc_op2), .acc_write(acc_write), .acc_el(acc_el),
    .acc_wdata(acc_wdata), .acc_claim(acc_claim), .acc_undef(acc_undef),
    .acc_rdata(acc_rdata), .busy(busy), .ram_req_valid(ram_req_valid),
    .ram_req_ready(ram_req_ready), .ram_sel(ram_sel), .ram_way(ram_way),
    .ram_loc(ram_loc), .ram_ofs(ram_ofs), .ram_rsp_valid(ram_rsp_valid),
    .ram_rsp_data(ram_rsp_data)
  );

  function automatic logic [31:0] model_word(logic [2:0] s, logic [WAY_W-1:0] w,
      logic [LOC_W-1:0] l, logic [OFS_W-1:0] o, int i);
    logic [31:0] k;
    k = {16'h0, s, w, l, o} ^ (32'(i) << 20);
    return (k * 32'h9E3779B1) ^ 32'h5A5A0000 ^ 32'(i);
  endfunction

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // RAM model: random accept, random response delay
  initial begin : ram_model
    bit pend = 0;
    int dly = 0;
    logic [RAM_W-1:0] d;
    forever begin
      @(negedge clk);
      ram_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          ram_rsp_valid = 1'b1;
          ram_rsp_data  = d;
          pend = 0;
        end else dly--;
      end
      ram_req_ready = ($urandom % 3) != 0;
      #1;
      if (ram_req_valid && ram_req_ready && rst_n) begin
        req_count++;
        check(ram_sel == exp_sel, "R1", "ram_sel", 128'(ram_sel), 128'(exp_sel));
        check(ram_way == exp_way && ram_loc == exp_loc, "R3", "way/loc",
              128'({ram_way, ram_loc}), 128'({exp_way, exp_loc}));
        check(ram_ofs == exp_ofs, "R3", "offset", 128'(ram_ofs), 128'(exp_ofs));
        for (int i = 0; i < 3; i++) d[i*32 +: 32] = model_word(ram_sel, ram_way, ram_loc, ram_ofs, i);
        pend = 1;
        dly = $urandom % 4;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  task automatic acc(logic [1:0] op0, logic [2:0] op1, logic [3:0] crn, logic [3:0] crm,
                     logic [2:0] op2, logic wr, logic [1:0] el, logic [31:0] wd, bit hold,
                     output logic first_ready);
    @(negedge clk);
    acc_op0 = op0; acc_op1 = op1; acc_crn = crn; acc_crm = crm; acc_op2 = op2;
    acc_write = wr; acc_el = el; acc_wdata = wd; acc_valid = 1'b1;
    #1;
    s_ready = acc_ready; s_claim = acc_claim; s_undef = acc_undef; s_rdata = acc_rdata;
    first_ready = s_ready;
    while (!s_ready && hold) begin
      @(negedge clk); #1;
      s_ready = acc_ready; s_claim = acc_claim; s_undef = acc_undef; s_rdata = acc_rdata;
    end
    if (s_ready) begin
      @(posedge clk); #1;
    end
    acc_valid = 1'b0;
  endtask

  task automatic read_word(int i, output logic [31:0] v);
    logic fr;
    acc(2'd3, 3'd3, 4'd15, 4'd0, 3'(i), 1'b0, 2'd3, 32'd0, 1'b1, fr);
    v = s_rdata;
  endtask

  task automatic tgt_code(int t, output logic [3:0] crm, output logic [2:0] op2);
    case (t)
      0: begin crm = 4'd2; op2 = 3'd0; end
      1: begin crm = 4'd2; op2 = 3'd1; end
      2: begin crm = 4'd4; op2 = 3'd0; end
      3: begin crm = 4'd4; op2 = 3'd1; end
      default: begin crm = 4'd4; op2 = 3'd2; end
    endcase
  endtask

  task automatic set_expect(int t, logic [31:0] wd);
    exp_sel = 3'(t);
    exp_way = wd[31:30];
    exp_loc = (t == 4) ? {1'b0, wd[12:6]} : wd[13:6];
    exp_ofs = (t == 2 || t == 3) ? wd[5:3] : 3'd0;
  endtask

  task automatic verify_bank(string req);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      read_word(i, v);
      check(v == shadow[i], req, $sformatf("result word %0d", i), 128'(v), 128'(shadow[i]));
    end
  endtask

  task automatic run_op(int t, logic [31:0] wd);
    logic [3:0] crm; logic [2:0] op2; logic fr; int rc;
    tgt_code(t, crm, op2);
    set_expect(t, wd);
    rc = req_count;
    acc(2'd3, 3'd3, 4'd15, crm, op2, 1'b1, 2'd3, wd, 1'b1, fr);
    check(s_ready && !s_undef && s_claim, "R2", "selector write accepted", 128'({s_claim, s_undef}), 128'(2'b10));
    // immediately after: lookup in flight, legal read must stall
    acc(2'd3, 3'd3, 4'd15, 4'd0, 3'd0, 1'b0, 2'd3, 32'd0, 1'b0, fr);
    check(!fr && busy, "R5", "read stalls while busy", 128'({fr, busy}), 128'(2'b01));
    // fault during flight: not stalled
    acc(2'd3, 3'd3, 4'd15, 4'd0, 3'd1, 1'b0, 2'($urandom % 3), 32'd0, 1'b0, fr);
    check(fr && s_undef, "R6", "low-EL read faults while busy", 128'({fr, s_undef}), 128'(2'b11));
    while (busy) @(negedge clk);
    check(req_count == rc + 1, "R2", "one request per write", 128'(req_count), 128'(rc + 1));
    for (int i = 0; i < 3; i++) shadow[i] = model_word(exp_sel, exp_way, exp_loc, exp_ofs, i);
    shadow[3] = 32'd0;
    verify_bank("R4");
  endtask

  initial begin : main
    logic fr; logic [3:0] crm; logic [2:0] op2; int rc;
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 4; i++) shadow[i] = 32'd0;
    exp_sel = '0; exp_way = '0; exp_loc = '0; exp_ofs = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!busy && !ram_req_valid, "R9", "idle after reset", 128'({busy, ram_req_valid}), 128'(0));
    verify_bank("R9");

    // directed: each target with corner words
    run_op(0, 32'hFFFF_FFFF);
    run_op(1, 32'h0000_0000);
    run_op(2, 32'h8000_3FF8);
    run_op(3, 32'h4000_0028);
    run_op(4, 32'hC000_3FFF);   // bit 13 set: must not reach TLB index
    check(shadow[3] == 32'd0, "R11", "upper word model", 128'(shadow[3]), 128'(0));

    // unclaimed encodings
    acc(2'd3, 3'd3, 4'd14, 4'd0, 3'd0, 1'b0, 2'd3, 32'd0, 1'b0, fr);
    check(!s_claim && !s_undef && s_rdata == 0, "R8", "CRn=14", 128'({s_claim, s_undef, s_rdata}), 128'(0));
    acc(2'd3, 3'd3, 4'd15, 4'd0, 3'd4, 1'b0, 2'd1, 32'd0, 1'b0, fr);
    check(!s_claim && !s_undef, "R8", "op2=4 on result row", 128'({s_claim, s_undef}), 128'(0));
    acc(2'd3, 3'd3, 4'd15, 4'd4, 3'd3, 1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0, fr);
    check(!s_claim && !s_undef && !busy, "R8", "CRm=4 op2=3 write", 128'({s_claim, s_undef, busy}), 128'(0));
    acc(2'd2, 3'd3, 4'd15, 4'd2, 3'd0, 1'b1, 2'd3, 32'h1, 1'b0, fr);
    check(!s_claim && !busy, "R8", "op0=2 write", 128'({s_claim, busy}), 128'(0));

    // wrong direction at EL3
    rc = req_count;
    acc(2'd3, 3'd3, 4'd15, 4'd0, 3'd2, 1'b1, 2'd3, 32'hDEAD_BEEF, 1'b0, fr);
    check(s_undef && fr, "R7", "write to result word", 128'({s_undef, fr}), 128'(2'b11));
    @(negedge clk);
    check(!busy && req_count == rc, "R7", "no launch", 128'(req_count), 128'(rc));
    for (int t = 0; t < 5; t++) begin
      tgt_code(t, crm, op2);
      acc(2'd3, 3'd3, 4'd15, crm, op2, 1'b0, 2'd3, 32'd0, 1'b0, fr);
      check(s_undef && s_rdata == 0, "R7", "read of selector", 128'({s_undef, s_rdata}), 128'({1'b1, 32'd0}));
    end
    verify_bank("R7");

    // low exception levels
    for (int el = 0; el < 3; el++) begin
      tgt_code(el + 2, crm, op2);
      acc(2'd3, 3'd3, 4'd15, crm, op2, 1'b1, 2'(el), 32'h1234_5678, 1'b0, fr);
      check(s_undef && fr, "R6", $sformatf("selector write at EL%0d", el), 128'({s_undef, fr}), 128'(2'b11));
      @(negedge clk);
      check(!busy && req_count == rc, "R6", "no request from low EL", 128'(req_count), 128'(rc));
      acc(2'd3, 3'd3, 4'd15, 4'd0, 3'(el), 1'b0, 2'(el), 32'd0, 1'b0, fr);
      check(s_undef && s_rdata == 0, "R6", "result read at low EL", 128'({s_undef, s_rdata}), 128'({1'b1, 32'd0}));
    end
    verify_bank("R10");

    // random mix
    for (int n = 0; n < 40; n++) begin
      int t;
      t = $urandom % 5;
      run_op(t, $urandom);
      if ((n % 5) == 0) begin
        tgt_code($urandom % 5, crm, op2);
        acc(2'd3, 3'd3, 4'd15, crm, op2, 1'b1, 2'($urandom % 3), $urandom, 1'b0, fr);
        check(s_undef, "R6", "random low-EL write", 128'(s_undef), 128'(1));
        verify_bank("R10");
      end
    end

    finish_up();
  end

endmodule